// File: doc/BRIEF.md
# Layer Resequencer for Spread Packet Flows

This block sits at the receiving end of a link where every source spreads its packet flow over several parallel layers. The sender deals successive packets of one flow to the layers in a fixed cyclic order. Each layer hands the receiver one packet per cycle, tagged with the index of its source. The packet lands in a small queue kept for that source and that layer. Each source has a pointer of its own that drains these queues in the same cyclic layer order the sender used. The flow therefore leaves in its original order without any sequence number in the packet.

Both ends share a mask of failed layers. Masked layers are passed over when a pointer steps and when it is parked on one. A pointer never jumps ahead to another layer. If a packet is lost, its source waits on the empty queue. A programmable time limit turns a long wait into a per-source stall flag. Sources with a packet ready take turns on one output stream.

Each layer input is valid/ready: a packet moves on a cycle where both are high. `in_ready` depends only on the tag and on whether the addressed queue has room, never on `in_valid`. The output is valid/ready as well. Once `out_valid` is high without `out_ready`, the same source and data stay offered until accepted. The one exception is a change of the failed-layer mask.

Top module: `layer_reseq`

## Requirements
- R1: After reset every source pointer is at layer 0, `out_valid` is low, every `stall` bit is low and every `in_ready` bit is high.
- R2: A layer input accepts a packet for source s only while the queue for (s, that layer) holds fewer than VIQ_DEPTH packets; `in_ready` for that layer is low while that queue is full, and is also low for a tag of NUM_SRC or more.
- R3: The packets of one source leave in the cyclic layer order 0, 1, ..., NUM_LAYER-1, 0, ..., with exactly one packet taken from a layer before the pointer moves on, and the pointer moves only on an output handshake for that source.
- R4: A source is offered on the output only when the queue at its pointed layer is non-empty; packets waiting on other layers of that source are never output early.
- R5: A layer whose bit in `fail_mask` is 1 is never read. A pointer that advances steps over such layers. A pointer parked on such a layer moves at once to the next live layer in the cyclic order.
- R6: When several sources are ready, they are served round-robin. The search starts one past the source of the last handshake, and source 0 follows the highest source.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_src` and `out_data` stay unchanged on the next cycle unless `fail_mask` changed.
- R8: `stall[s]` is high in a cycle exactly when the pointed queue of source s is empty, some other queue of source s holds a packet, and this has held for more than `stall_limit` consecutive cycles, counting the current one. A stalled source is never on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_mask | input | NUM_LAYER | 1 marks a failed layer to be skipped |
| stall_limit | input | STALL_W | Consecutive waiting cycles tolerated before a stall flag rises |
| in_valid | input | NUM_LAYER | Per-layer packet valid |
| in_src | input | NUM_LAYER*SRC_W | Per-layer source tag, layer l in bits [l*SRC_W +: SRC_W] |
| in_data | input | NUM_LAYER*DATA_W | Per-layer payload, layer l in bits [l*DATA_W +: DATA_W] |
| in_ready | output | NUM_LAYER | Per-layer room in the addressed queue |
| out_valid | output | 1 | Output packet valid |
| out_ready | input | 1 | Downstream accepts the output packet |
| out_src | output | SRC_W | Source of the output packet |
| out_data | output | DATA_W | Payload of the output packet |
| stall | output | NUM_SRC | Per-source sequence stall flag |

## Verification
The bench builds the block with three sources, four layers, two-entry queues and 8-bit data. A source count that is not a power of two exercises the wrap of the round-robin search. Two-entry queues reach the full condition in two writes. With four layers, one failed layer can be skipped both while parked and while advancing. A stall limit of 3 lets the flag's exact rising cycle be pinned down within a few cycles.

// File: rtl/reseq_pkg.sv
package reseq_pkg;
  localparam int unsigned RING_MAX = 32;

  // First index at or after start (cyclic over n) whose ok bit is set.
  function automatic int unsigned ring_pick(int unsigned start, logic [RING_MAX-1:0] ok,
                                            int unsigned n);
    int unsigned idx;
    ring_pick = start;
    for (int i = RING_MAX - 1; i >= 0; i--) begin
      if (i < int'(n)) begin
        idx = (start + i) % n;
        if (ok[idx]) ring_pick = idx;
      end
    end
  endfunction
endpackage

// File: rtl/reseq_viq.sv
module reseq_viq #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/reseq_poller.sv
module reseq_poller
  import reseq_pkg::*;
#(
  parameter int NUM_LAYER = 4,
  parameter int LAY_W     = 2,
  parameter int STALL_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LAYER-1:0] live,
  input  logic [NUM_LAYER-1:0] has_data,
  input  logic               adv,
  input  logic [STALL_W-1:0] stall_limit,
  output logic [LAY_W-1:0]   sel_layer,
  output logic               ready,
  output logic               stall
);
  logic [LAY_W-1:0]   ptr_q;
  logic [STALL_W-1:0] wait_q;
  logic [RING_MAX-1:0] live32;
  int unsigned        eff, nxt;
  logic               waiting;

  always_comb begin
    live32 = '0;
    live32[NUM_LAYER-1:0] = live;
    eff = ring_pick(int'(ptr_q), live32, NUM_LAYER);
    nxt = ring_pick((eff + 1) % NUM_LAYER, live32, NUM_LAYER);
  end

  assign sel_layer = LAY_W'(eff);
  assign ready     = has_data[sel_layer] && live[sel_layer];
  assign waiting   = !ready && (|has_data);
  assign stall     = waiting && (wait_q >= stall_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wait_q <= '0;
    end else begin
      ptr_q <= adv ? LAY_W'(nxt) : sel_layer;
      if (!waiting)             wait_q <= '0;
      else if (wait_q != '1)    wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/reseq_arb.sv
module reseq_arb
  import reseq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               accept,
  output logic [SRC_W-1:0]   grant,
  output logic               any
);
  logic [SRC_W-1:0]    rr_q, lock_src_q;
  logic                lock_q;
  logic [RING_MAX-1:0] req32;
  int unsigned         pick;

  always_comb begin
    req32 = '0;
    req32[NUM_SRC-1:0] = req;
    pick  = ring_pick(int'(rr_q), req32, NUM_SRC);
    grant = (lock_q && req[lock_src_q]) ? lock_src_q : SRC_W'(pick);
  end

  assign any = |req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q       <= '0;
      lock_q     <= 1'b0;
      lock_src_q <= '0;
    end else if (accept) begin
      rr_q   <= (int'(grant) == NUM_SRC - 1) ? '0 : grant + 1'b1;
      lock_q <= 1'b0;
    end else if (any) begin
      lock_q     <= 1'b1;
      lock_src_q <= grant;
    end
  end
endmodule

// File: rtl/layer_reseq.sv
module layer_reseq #(
  parameter int NUM_SRC   = 4,
  parameter int NUM_LAYER = 4,
  parameter int VIQ_DEPTH = 4,
  parameter int DATA_W    = 32,
  parameter int STALL_W   = 16,
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LAY_W    = (NUM_LAYER > 1) ? $clog2(NUM_LAYER) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LAYER-1:0]        fail_mask,
  input  logic [STALL_W-1:0]          stall_limit,
  input  logic [NUM_LAYER-1:0]        in_valid,
  input  logic [NUM_LAYER*SRC_W-1:0]  in_src,
  input  logic [NUM_LAYER*DATA_W-1:0] in_data,
  output logic [NUM_LAYER-1:0]        in_ready,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [SRC_W-1:0]            out_src,
  output logic [DATA_W-1:0]           out_data,
  output logic [NUM_SRC-1:0]          stall
);
  localparam int NQ = NUM_SRC * NUM_LAYER;

  logic [NQ-1:0]       fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DATA_W-1:0]   head_a [NQ];
  logic [LAY_W-1:0]    sel_layer_a [NUM_SRC];
  logic [NUM_SRC-1:0]  src_req, adv;
  logic [SRC_W-1:0]    grant;
  logic [LAY_W-1:0]    out_layer;
  logic                hs;

  // Per-layer admission: room in the queue named by the tag.
  always_comb begin
    for (int l = 0; l < NUM_LAYER; l++) begin
      in_ready[l] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (in_src[l*SRC_W +: SRC_W] == SRC_W'(s)) in_ready[l] = !fifo_full[s*NUM_LAYER + l];
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar l = 0; l < NUM_LAYER; l++) begin : g_lay
      localparam int Q = s * NUM_LAYER + l;
      assign fifo_push[Q] = in_valid[l] && in_ready[l] &&
                            (in_src[l*SRC_W +: SRC_W] == SRC_W'(s));
      assign fifo_pop[Q]  = adv[s] && (sel_layer_a[s] == LAY_W'(l));
      reseq_viq #(.DATA_W(DATA_W), .DEPTH(VIQ_DEPTH)) u_viq (
        .clk(clk), .rst_n(rst_n),
        .push(fifo_push[Q]), .push_data(in_data[l*DATA_W +: DATA_W]),
        .pop(fifo_pop[Q]), .head(head_a[Q]),
        .empty(fifo_empty[Q]), .full(fifo_full[Q])
      );
    end

    assign adv[s] = hs && (grant == SRC_W'(s));

    reseq_poller #(.NUM_LAYER(NUM_LAYER), .LAY_W(LAY_W), .STALL_W(STALL_W)) u_poll (
      .clk(clk), .rst_n(rst_n),
      .live(~fail_mask),
      .has_data(~fifo_empty[s*NUM_LAYER +: NUM_LAYER]),
      .adv(adv[s]),
      .stall_limit(stall_limit),
      .sel_layer(sel_layer_a[s]),
      .ready(src_req[s]),
      .stall(stall[s])
    );
  end

  reseq_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(src_req), .accept(hs),
    .grant(grant), .any(out_valid)
  );

  assign hs        = out_valid && out_ready;
  assign out_src   = grant;
  assign out_layer = sel_layer_a[grant];
  assign out_data  = head_a[int'(grant) * NUM_LAYER + int'(out_layer)];
endmodule

// File: rtl/reseq_checker.sv
module reseq_checker #(
  parameter int NUM_SRC   = 4,
  parameter int NUM_LAYER = 4,
  parameter int DATA_W    = 32,
  parameter int SRC_W     = 2,
  parameter int LAY_W     = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_SRC*NUM_LAYER-1:0] fifo_push,
  input logic [NUM_SRC*NUM_LAYER-1:0] fifo_full,
  input logic [NUM_LAYER-1:0]         fail_mask,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [SRC_W-1:0]             out_src,
  input logic [DATA_W-1:0]            out_data,
  input logic [LAY_W-1:0]             out_layer,
  input logic [NUM_SRC-1:0]           stall
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push & fifo_full) == '0);

  a_r5_live_layer: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fail_mask[out_layer]);

  a_r6_src_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_src) < NUM_SRC));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (fail_mask != $past(fail_mask)) ||
      (out_valid && out_src == $past(out_src) && out_data == $past(out_data)));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_st
    a_r8_stall_not_out: assert property (@(posedge clk) disable iff (!rst_n)
      stall[s] |-> !(out_valid && out_src == SRC_W'(s)));
  end
endmodule

bind layer_reseq reseq_checker #(
  .NUM_SRC(NUM_SRC), .NUM_LAYER(NUM_LAYER), .DATA_W(DATA_W),
  .SRC_W(SRC_W), .LAY_W(LAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_push(fifo_push), .fifo_full(fifo_full),
  .fail_mask(fail_mask), .out_valid(out_valid), .out_ready(out_ready),
  .out_src(out_src), .out_data(out_data), .out_layer(out_layer), .stall(stall)
);

// File: tb/sim_layer_reseq.sv
module sim_layer_reseq;
  localparam int S = 3, L = 4, D = 2, DW = 8, SW = 4, SRCW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [L-1:0]    fail_mask = '0;
  logic [SW-1:0]   stall_limit = 4'd3;
  logic [L-1:0]    in_valid = '0;
  logic [L*SRCW-1:0] in_src = '0;
  logic [L*DW-1:0] in_data = '0;
  logic [L-1:0]    in_ready;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [SRCW-1:0] out_src;
  logic [DW-1:0]   out_data;
  logic [S-1:0]    stall;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  layer_reseq #(.NUM_SRC(S), .NUM_LAYER(L), .VIQ_DEPTH(D), .DATA_W(DW), .STALL_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .fail_mask(fail_mask), .stall_limit(stall_limit),
    .in_valid(in_valid), .in_src(in_src), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
    .out_data(out_data), .stall(stall)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(bit en, int lay, logic [1:0] src, logic [7:0] d);
    in_valid = '0; in_src = '0; in_data = '0;
    if (en) begin
      in_valid[lay] = 1'b1;
      in_src[lay*SRCW +: SRCW] = src;
      in_data[lay*DW +: DW] = d;
    end
  endtask

  // {en, layer, src, data, out_ready, exp_valid, exp_src, exp_data}
  localparam logic [24:0] VEC [12] = '{
    {1'b1, 2'd1, 2'd0, 8'h11, 1'b1, 1'b0, 2'd0, 8'h00},
    {1'b1, 2'd0, 2'd0, 8'h10, 1'b1, 1'b0, 2'd0, 8'h00},
    {1'b1, 2'd0, 2'd1, 8'h20, 1'b0, 1'b1, 2'd0, 8'h10},
    {1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h10},
    {1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd1, 8'h20},
    {1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h11},
    {1'b1, 2'd3, 2'd0, 8'h13, 1'b1, 1'b0, 2'd0, 8'h00},
    {1'b1, 2'd2, 2'd0, 8'h12, 1'b1, 1'b0, 2'd0, 8'h00},
    {1'b1, 2'd0, 2'd2, 8'h30, 1'b1, 1'b1, 2'd0, 8'h12},
    {1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd2, 8'h30},
    {1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0, 8'h13},
    {1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00}
  };

  task automatic expect_out(string req, bit v, logic [1:0] s, logic [7:0] d);
    check({req, " out_valid"}, 32'(out_valid), 32'(v));
    if (v) begin
      check({req, " out_src"}, 32'(out_src), 32'(s));
      check({req, " out_data"}, 32'(out_data), 32'(d));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 stall", 32'(stall), 0);
    check("R1 in_ready", 32'(in_ready), 32'hF);
    @(posedge clk);

    // Table: R3 order, R4 no early read, R6 round-robin, R7 hold
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      drive(VEC[i][24], int'(VEC[i][23:22]), VEC[i][21:20], VEC[i][19:12]);
      out_ready = VEC[i][11];
      #1;
      expect_out($sformatf("R3/R4/R6/R7 vec%0d", i), VEC[i][10], VEC[i][9:8], VEC[i][7:0]);
      check("R8 no stall in table", 32'(stall), 0);
      @(posedge clk);
    end
    out_ready = 1'b1;

    // R2 full queue and R8 stall timing on source 2 (pointer at layer 1)
    @(negedge clk); drive(1, 3, 2'd2, 8'h33); @(posedge clk);
    @(negedge clk); drive(1, 3, 2'd2, 8'h34); #1;
    check("R8 stall n1", 32'(stall[2]), 0);
    @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0); in_src[3*SRCW +: SRCW] = 2'd2; #1;
    check("R2 in_ready low when full", 32'(in_ready[3]), 0);
    check("R8 stall n2", 32'(stall[2]), 0);
    in_src[3*SRCW +: SRCW] = 2'd1; #1;
    check("R2 in_ready other source", 32'(in_ready[3]), 1);
    @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0); #1;
    check("R8 stall n3", 32'(stall[2]), 0);
    @(posedge clk);
    @(negedge clk); #1;
    check("R8 stall n4", 32'(stall), 32'b100);
    expect_out("R4 wait on pointed layer", 0, 0, 0);
    drive(1, 1, 2'd2, 8'h31);
    @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0); #1;
    check("R8 stall clears", 32'(stall[2]), 0);
    expect_out("R3 layer1 of src2", 1, 2'd2, 8'h31);
    @(posedge clk);

    // R5 failed layer: parked skip, then advance skip
    @(negedge clk); #1;
    expect_out("R4 layer2 empty", 0, 0, 0);
    fail_mask = 4'b0100; #1;
    expect_out("R5 parked skip", 1, 2'd2, 8'h33);
    @(posedge clk);
    @(negedge clk); #1;
    expect_out("R3 wrap to layer0", 0, 0, 0);
    drive(1, 0, 2'd2, 8'h40); @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0); #1;
    expect_out("R3 layer0 of src2", 1, 2'd2, 8'h40);
    @(posedge clk);
    @(negedge clk); drive(1, 1, 2'd2, 8'h41); @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0); #1;
    expect_out("R3 layer1 of src2", 1, 2'd2, 8'h41);
    @(posedge clk);
    @(negedge clk); #1;
    expect_out("R5 advance skip", 1, 2'd2, 8'h34);
    @(posedge clk);
    @(negedge clk); #1;
    expect_out("R5 drained", 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule